// File: doc/BRIEF.md
# I2C Master-Receive Byte Counter with Block Refill

This block sits between the bit-level engine of an I2C master receiver and the software-facing receive data register. The engine hands over each complete byte as a one-cycle strobe with its data. The block counts those bytes against a programmed block size of 1 to 255 bytes and stages them through a one-byte holding slot into a data register. It also asks the engine to hold SCL low whenever the receive path cannot take another byte.

Transfers longer than 255 bytes are split into blocks by setting the refill mode when the count is written. When a block's last byte arrives in refill mode, a refill request flag rises and, with stretching enabled, SCL is held until software writes the next nonzero count. The last byte of the block is never lost to this pause. It waits in the holding slot and moves into the data register on the cycle the previous byte is read, whatever the refill state. This holds even when that read lands just before, on, or just after the cycle the flag rises. Without refill mode, the end of the count raises a transfer-done flag instead.

Top module: `i2c_rx_count_ctrl`

## Requirements
- R1: While rst_n is low, count_left is 0 and rx_valid, refill_req, xfer_done and scl_hold are all 0.
- R2: A cfg_wr with a nonzero cfg_count loads count_left with that value at the next clock edge, latches cfg_reload as the block's mode, and clears refill_req and xfer_done. A cfg_wr with cfg_count equal to 0 changes neither the count nor the flags.
- R3: A byte strobe is accepted only while count_left is nonzero and no byte waits in the holding slot. Each accepted byte lowers count_left by exactly 1 at that clock edge. A strobe that is not accepted leaves the count and the data path unchanged.
- R4: In refill mode, the accepted byte that takes count_left from 1 to 0 sets refill_req at the same edge. refill_req then stays set until a nonzero count write.
- R5: scl_hold is 1 exactly when a byte waits in the holding slot, or when refill_req is set and stretch_en is 1.
- R6: With refill mode clear, the byte that takes count_left to 0 sets xfer_done and leaves refill_req at 0. The two flags are never set together.
- R7: An accepted byte goes straight into the data register when that register is empty or is read in the same cycle. Otherwise it waits in the holding slot and moves into the data register at the edge of the next read. rx_valid is 1 while the data register holds an unread byte. Bytes come out in arrival order and none is dropped, whatever the timing of the read against refill_req rising.
- R8: A rd_strobe while rx_valid is 0 has no effect on any output.
- R9: With stretch_en at 0, refill_req still rises at the end of a refill block, but scl_hold stays 0 unless a byte is waiting in the holding slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | One-cycle write of a new block count |
| cfg_count | input | 8 | Block size in bytes, 1 to 255; 0 is ignored |
| cfg_reload | input | 1 | Mode written with the count: 1 selects refill at block end |
| stretch_en | input | 1 | Allows SCL hold while a refill is pending |
| byte_vld | input | 1 | One-cycle strobe from the bit engine: a byte has been received |
| byte_data | input | 8 | The received byte, valid with byte_vld |
| rd_strobe | input | 1 | One-cycle read of the data register |
| rx_data | output | 8 | Data register contents |
| rx_valid | output | 1 | Data register holds an unread byte |
| count_left | output | 8 | Bytes still expected in the current block |
| refill_req | output | 1 | Refill block exhausted; waiting for a new count |
| xfer_done | output | 1 | Non-refill block exhausted |
| scl_hold | output | 1 | Request to the bit engine to hold SCL low |

## Verification
The checker watches several rules on every cycle. These are the hold request during a stretch-enabled refill, the exclusivity of the two end flags, the persistence of refill_req, the loading of a nonzero count, the refusal of a zero count, and the stability of an unread data register. Ordering and loss of bytes cannot be seen from one cycle. These are shown by the bench's behavioural queue model, compared every clock. Directed runs place the read of byte N-1 one cycle before, on, and after the arrival of a block's last byte, and stretching is also turned off.

// File: rtl/i2c_rx_cnt_pkg.sv
package i2c_rx_cnt_pkg;
    // Default widths shared by the counter, buffer and top.
    localparam int unsigned RX_DATA_W = 8;
    localparam int unsigned RX_CNT_W  = 8;
endpackage

// File: rtl/rx_byte_counter.sv
module rx_byte_counter
    import i2c_rx_cnt_pkg::*;
#(
    parameter int unsigned CNT_W = RX_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_en,
    input  logic [CNT_W-1:0] load_val,
    input  logic             load_refill,
    input  logic             byte_take,
    output logic [CNT_W-1:0] count,
    output logic             active,
    output logic             refill,
    output logic             done
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             mode_refill;
        logic             refill;
        logic             done;
    } cnt_state_t;

    cnt_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (load_en && (load_val != '0)) begin
            s_d.cnt         = load_val;
            s_d.mode_refill = load_refill;
            s_d.refill      = 1'b0;
            s_d.done        = 1'b0;
        end else if (byte_take && (s_q.cnt != '0)) begin
            s_d.cnt = s_q.cnt - ONE;
            if (s_q.cnt == ONE) begin
                if (s_q.mode_refill) begin
                    s_d.refill = 1'b1;
                end else begin
                    s_d.done = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign count  = s_q.cnt;
    assign active = (s_q.cnt != '0);
    assign refill = s_q.refill;
    assign done   = s_q.done;
endmodule

// File: rtl/rx_byte_buffer.sv
module rx_byte_buffer
    import i2c_rx_cnt_pkg::*;
#(
    parameter int unsigned DATA_W = RX_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_vld,
    input  logic [DATA_W-1:0] in_data,
    input  logic              rd,
    output logic [DATA_W-1:0] dat,
    output logic              full,
    output logic              pend
);
    typedef struct packed {
        logic [DATA_W-1:0] dat;
        logic              full;
        logic [DATA_W-1:0] sh;
        logic              sh_full;
    } buf_state_t;

    buf_state_t s_d, s_q;
    logic       rd_ok;

    always_comb begin
        rd_ok = rd && s_q.full;
        s_d   = s_q;
        // Read first: a waiting byte moves up on the read edge.
        if (rd_ok) begin
            if (s_q.sh_full) begin
                s_d.dat     = s_q.sh;
                s_d.sh_full = 1'b0;
            end else begin
                s_d.full = 1'b0;
            end
        end
        // New byte: direct when the register is free this edge, else wait.
        if (in_vld) begin
            if (!s_q.full || (rd_ok && !s_q.sh_full)) begin
                s_d.dat  = in_data;
                s_d.full = 1'b1;
            end else begin
                s_d.sh      = in_data;
                s_d.sh_full = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign dat  = s_q.dat;
    assign full = s_q.full;
    assign pend = s_q.sh_full;
endmodule

// File: rtl/i2c_rx_count_ctrl.sv
module i2c_rx_count_ctrl
    import i2c_rx_cnt_pkg::*;
#(
    parameter int unsigned DATA_W = RX_DATA_W,
    parameter int unsigned CNT_W  = RX_CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [CNT_W-1:0]  cfg_count,
    input  logic              cfg_reload,
    input  logic              stretch_en,
    input  logic              byte_vld,
    input  logic [DATA_W-1:0] byte_data,
    input  logic              rd_strobe,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    output logic [CNT_W-1:0]  count_left,
    output logic              refill_req,
    output logic              xfer_done,
    output logic              scl_hold
);
    logic cnt_active;
    logic slot_busy;
    logic take;

    // A byte counts only inside a block and only if the slot is free.
    assign take = byte_vld && cnt_active && !slot_busy;

    rx_byte_counter #(
        .CNT_W (CNT_W)
    ) u_counter (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_en     (cfg_wr),
        .load_val    (cfg_count),
        .load_refill (cfg_reload),
        .byte_take   (take),
        .count       (count_left),
        .active      (cnt_active),
        .refill      (refill_req),
        .done        (xfer_done)
    );

    rx_byte_buffer #(
        .DATA_W (DATA_W)
    ) u_buffer (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_vld  (take),
        .in_data (byte_data),
        .rd      (rd_strobe),
        .dat     (rx_data),
        .full    (rx_valid),
        .pend    (slot_busy)
    );

    assign scl_hold = slot_busy || (refill_req && stretch_en);
endmodule

// File: rtl/i2c_rx_count_checker.sv
module i2c_rx_count_checker #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned CNT_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_wr,
    input logic [CNT_W-1:0]  cfg_count,
    input logic              byte_vld,
    input logic              rd_strobe,
    input logic              stretch_en,
    input logic [DATA_W-1:0] rx_data,
    input logic              rx_valid,
    input logic [CNT_W-1:0]  count_left,
    input logic              refill_req,
    input logic              xfer_done,
    input logic              scl_hold
);
    a_r5_refill_holds_scl: assert property (@(posedge clk) disable iff (!rst_n)
        (refill_req && stretch_en) |-> scl_hold);

    a_r6_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(refill_req && xfer_done));

    a_r4_refill_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (refill_req && !(cfg_wr && cfg_count != '0)) |=> refill_req);

    a_r2_count_load: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_count != '0) |=>
            (count_left == $past(cfg_count)) && !refill_req && !xfer_done);

    a_r2_zero_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_count == '0 && !byte_vld) |=> $stable(count_left));

    a_r7_unread_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !rd_strobe) |=> (rx_valid && $stable(rx_data)));

    a_r8_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_valid && !byte_vld) |=> !rx_valid);

    a_r3_idle_ignores: assert property (@(posedge clk) disable iff (!rst_n)
        (count_left == '0 && !cfg_wr) |=> $stable(count_left));
endmodule

bind i2c_rx_count_ctrl i2c_rx_count_checker #(
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W)
) u_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_wr     (cfg_wr),
    .cfg_count  (cfg_count),
    .byte_vld   (byte_vld),
    .rd_strobe  (rd_strobe),
    .stretch_en (stretch_en),
    .rx_data    (rx_data),
    .rx_valid   (rx_valid),
    .count_left (count_left),
    .refill_req (refill_req),
    .xfer_done  (xfer_done),
    .scl_hold   (scl_hold)
);

// File: tb/test_i2c_rx_count_ctrl.sv
module test_i2c_rx_count_ctrl;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [7:0] cfg_count = '0;
    logic       cfg_reload = 1'b0;
    logic       stretch_en = 1'b1;
    logic       byte_vld = 1'b0;
    logic [7:0] byte_data = '0;
    logic       rd_strobe = 1'b0;
    logic [7:0] rx_data;
    logic       rx_valid;
    logic [7:0] count_left;
    logic       refill_req;
    logic       xfer_done;
    logic       scl_hold;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_rx_count_ctrl i_i2c_rx_count_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_count(cfg_count),
        .cfg_reload(cfg_reload), .stretch_en(stretch_en), .byte_vld(byte_vld),
        .byte_data(byte_data), .rd_strobe(rd_strobe), .rx_data(rx_data),
        .rx_valid(rx_valid), .count_left(count_left), .refill_req(refill_req),
        .xfer_done(xfer_done), .scl_hold(scl_hold)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s t=%0t actual=%0d expected=%0d", req, $time, act, exp);
        end
    endtask

    // Behavioural reference: a queue holds data register then holding slot.
    int unsigned     m_cnt;
    bit              m_mode, m_refill, m_done;
    byte unsigned    m_q[$];
    bit              m_acc;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_mode = 0; m_refill = 0; m_done = 0;
            m_q.delete();
        end else begin
            m_acc = byte_vld && (m_cnt > 0) && (m_q.size() < 2);
            if (rd_strobe && m_q.size() > 0) void'(m_q.pop_front());
            if (m_acc) m_q.push_back(byte_data);
            if (cfg_wr && cfg_count != 0) begin
                m_cnt = cfg_count; m_mode = cfg_reload; m_refill = 0; m_done = 0;
            end else if (m_acc) begin
                m_cnt--;
                if (m_cnt == 0) begin
                    if (m_mode) m_refill = 1; else m_done = 1;
                end
            end
        end
        #1;
        chk(rx_valid == (m_q.size() > 0), "R7 rx_valid", rx_valid, m_q.size() > 0);
        if (m_q.size() > 0)
            chk(rx_data == m_q[0], "R7 rx_data", rx_data, m_q[0]);
        chk(count_left == m_cnt, "R3 count_left", count_left, m_cnt);
        chk(refill_req == m_refill, "R4 refill_req", refill_req, m_refill);
        chk(xfer_done == m_done, "R6 xfer_done", xfer_done, m_done);
        chk(scl_hold == ((m_q.size() > 1) || (m_refill && stretch_en)),
            "R5 scl_hold", scl_hold, (m_q.size() > 1) || (m_refill && stretch_en));
    end

    task automatic tick();
        @(negedge clk);
        cfg_wr = 0; byte_vld = 0; rd_strobe = 0;
    endtask

    task automatic load(input int n, input bit rl);
        cfg_wr = 1; cfg_count = 8'(n); cfg_reload = rl; tick();
    endtask

    task automatic send(input int d, input bit rd);
        byte_vld = 1; byte_data = 8'(d); rd_strobe = rd; tick();
    endtask

    task automatic rd();
        rd_strobe = 1; tick();
    endtask

    initial begin
        @(negedge clk);
        // R1: reset values
        chk(count_left == 0 && !rx_valid && !refill_req && !xfer_done && !scl_hold,
            "R1 reset", {count_left, rx_valid, refill_req, xfer_done, scl_hold}, 0);
        tick(); rst_n = 1; tick();

        // R2: zero count ignored
        load(0, 1);
        chk(count_left == 0, "R2 zero count", count_left, 0);
        // R3: byte outside a block ignored
        send(8'h11, 0);
        chk(!rx_valid, "R3 idle byte", rx_valid, 0);
        // R8: read on empty register
        rd();
        chk(!rx_valid && count_left == 0, "R8 empty read", rx_valid, 0);

        // R6: plain block of 3, read promptly
        load(3, 0);
        chk(count_left == 3, "R2 load", count_left, 3);
        send(8'hA1, 0); rd();
        send(8'hA2, 0); rd();
        send(8'hA3, 0);
        chk(xfer_done && !refill_req, "R6 done", {xfer_done, refill_req}, 2);
        chk(rx_data == 8'hA3, "R7 last data", rx_data, 8'hA3);
        rd();

        // R4/R7: last byte arrives while previous unread
        load(2, 1);
        send(8'hB1, 0);
        send(8'hB2, 0);
        chk(refill_req && scl_hold && rx_data == 8'hB1, "R4 refill late read",
            {refill_req, scl_hold}, 3);
        send(8'hEE, 0);   // held engine: ignored
        rd();
        chk(rx_data == 8'hB2 && rx_valid, "R7 moved on read", rx_data, 8'hB2);
        chk(scl_hold, "R5 hold while refill", scl_hold, 1);
        rd();
        load(2, 1);
        chk(!refill_req && !scl_hold && count_left == 2, "R2 refill cleared",
            {refill_req, scl_hold}, 0);

        // R7: read on the same cycle as the last byte
        send(8'hC1, 0);
        send(8'hC2, 1);
        chk(rx_data == 8'hC2 && refill_req && !scl_hold == 0, "R7 same-cycle read",
            rx_data, 8'hC2);
        rd();
        // R7: read one cycle before the last byte
        load(2, 1);
        send(8'hD1, 0);
        rd();
        send(8'hD2, 0);
        chk(rx_data == 8'hD2 && rx_valid && refill_req, "R7 early read", rx_data, 8'hD2);
        rd();

        // R9: stretching disabled
        stretch_en = 0;
        load(1, 1);
        send(8'hF1, 0);
        chk(refill_req && !scl_hold, "R9 no stretch", {refill_req, scl_hold}, 2);
        rd();
        stretch_en = 1;
        @(negedge clk);
        chk(scl_hold, "R9 stretch re-enabled", scl_hold, 1);
        load(4, 0);
        send(8'h51, 0); send(8'h52, 0);
        chk(scl_hold && count_left == 2, "R5 slot hold", {scl_hold, count_left}, 258);
        rd(); rd();
        repeat (3) tick();

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog R1 actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule